// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block is the controller-side engine that takes a DDR-style DRAM from power-on to an idle, configured state. After reset it keeps clock-enable low for a long stabilization interval. It then raises clock-enable and sends no-operation commands. Next it closes all banks with a precharge-all command. It writes the extended mode register, which carries drive strength, on-die termination and DLL control. Last it writes the mode register and raises a done flag. From then on it drives only no-operation commands, so the normal memory controller can take over the command bus.

The extended and mode register contents come from configuration inputs. These inputs must stay stable while the sequence runs. A mode input picks one of two extended-register styles. In the split style, the termination and drive settings are written first with the DLL disabled, and a second write then enables the DLL. In the merged style, one write carries the settings and enables the DLL. All waits are counted in clock cycles and set by parameters. The stabilization count defaults to 200 µs at a 250 MHz clock.

Top module: `dram_init_seq`

## Requirements
- R1: While reset is high, and for `STABLE_CYC` clock edges after reset is released, `cke` is 0, `init_done` is 0 and the bus carries a NOP. A NOP is `cs_n`=0, `ras_n`=`cas_n`=`we_n`=1, `ba`=0 and `addr`=0.
- R2: After the stabilization interval, `cke` is 1 and the bus carries a NOP for `WAKE_CYC` cycles. `cke` then stays 1 until the next reset.
- R3: Next comes a precharge-all command for one cycle: `cs_n`, `ras_n` and `we_n` are 0, `cas_n` is 1, `ba` is 0, and `addr` has only bit 8 set. The next command comes `TRP_CYC` cycles later.
- R4: With `merge_dll`=0, the first register write is an extended write (all four command pins 0, `ba`=01) whose `addr` is `emr_cfg` with bit 0 forced to 1, which disables the DLL. `TMRD_CYC` cycles later a second extended write sends `emr_cfg` with bit 0 forced to 0, which enables the DLL.
- R5: With `merge_dll`=1, a single extended write sends `emr_cfg` with bit 0 forced to 0. Termination and DLL enable go out together.
- R6: A mode register write (all four command pins 0, `ba`=00, `addr`=`mr_cfg`) comes `TMRD_CYC` cycles after the last extended write. It never comes before the DLL-enabling extended write.
- R7: Every command lasts exactly one cycle, and only NOPs appear between commands. `TRP_CYC` and `TMRD_CYC` are at least 2.
- R8: `init_done` rises `TMRD_CYC` cycles after the mode register write and stays 1 until reset. While `init_done` is 1 the bus carries only NOPs.
- R9: Asserting reset at any point of the sequence returns the block to the R1 state, and the sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| merge_dll | input | 1 | 1: one extended write with DLL on; 0: DLL-off write, then DLL-on write |
| emr_cfg | input | ADDR_W | Extended mode register value (bit 0 is DLL disable) |
| mr_cfg | input | ADDR_W | Mode register value |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / register select |
| addr | output | ADDR_W | Address bus carrying register contents |
| init_done | output | 1 | Sequence complete, DRAM idle and configured |

## Verification
The hardest state to reach from the ports is a reset that lands partway through the sequence. Examples are a reset between the two extended writes, or during a register-write wait. In those cases the block must drop `cke` and restart cleanly, without leaving a half-finished register write behind. The stimulus runs the sequence for a random number of cycles, from the seeded generator, and then pulses reset. After that it runs a complete sequence and compares every cycle, so restarts from many different phases are covered. Directed runs add the all-ones and all-zeros register patterns in both extended-write styles.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [2:0] {
        PH_HOLD,
        PH_WAKE,
        PH_PREA,
        PH_EMR_OFF,
        PH_EMR_ON,
        PH_MRS,
        PH_READY
    } init_phase_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } dram_cmd_t;

    localparam dram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam dram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam dram_cmd_t CMD_MRW = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam logic [1:0] SEL_MR  = 2'b00;
    localparam logic [1:0] SEL_EMR = 2'b01;

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic init_phase_e next_phase(init_phase_e p, logic merge);
        case (p)
            PH_HOLD:    return PH_WAKE;
            PH_WAKE:    return PH_PREA;
            PH_PREA:    return merge ? PH_EMR_ON : PH_EMR_OFF;
            PH_EMR_OFF: return PH_EMR_ON;
            PH_EMR_ON:  return PH_MRS;
            default:    return PH_READY;
        endcase
    endfunction

endpackage

// File: rtl/init_step_timer.sv
module init_step_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] dwell_m1,
    output logic             first,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign first = (cnt == '0);
    assign last  = (cnt == dwell_m1);
endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
    import dram_init_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DLL_BIT  = 0,
    parameter int unsigned PALL_BIT = 8
) (
    input  init_phase_e       phase,
    input  logic              first,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic [ADDR_W-1:0] mr_cfg,
    output logic              cke,
    output dram_cmd_t         cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_BIT;
    localparam logic [ADDR_W-1:0] PALL_MASK = ADDR_W'(1) << PALL_BIT;

    always_comb begin
        cke   = (phase != PH_HOLD);
        ready = (phase == PH_READY);
        cmd   = CMD_NOP;
        ba    = '0;
        addr  = '0;
        if (first) begin
            case (phase)
                PH_PREA: begin
                    cmd  = CMD_PRE;
                    addr = PALL_MASK;
                end
                PH_EMR_OFF: begin
                    cmd  = CMD_MRW;
                    ba   = SEL_EMR;
                    addr = emr_cfg | DLL_MASK;
                end
                PH_EMR_ON: begin
                    cmd  = CMD_MRW;
                    ba   = SEL_EMR;
                    addr = emr_cfg & ~DLL_MASK;
                end
                PH_MRS: begin
                    cmd  = CMD_MRW;
                    ba   = SEL_MR;
                    addr = mr_cfg;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned STABLE_CYC = 50000,
    parameter int unsigned WAKE_CYC   = 2,
    parameter int unsigned TRP_CYC    = 4,
    parameter int unsigned TMRD_CYC   = 2,
    parameter int unsigned DLL_BIT    = 0,
    parameter int unsigned PALL_BIT   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              merge_dll,
    input  logic [ADDR_W-1:0] emr_cfg,
    input  logic [ADDR_W-1:0] mr_cfg,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int unsigned MAX_DWELL =
        max_of(max_of(STABLE_CYC, WAKE_CYC), max_of(TRP_CYC, TMRD_CYC));
    localparam int unsigned CNT_W = $clog2(MAX_DWELL + 1);

    init_phase_e      phase;
    logic             first;
    logic             last;
    logic [CNT_W-1:0] dwell_m1;
    dram_cmd_t        cmd;

    always_comb begin
        case (phase)
            PH_HOLD: dwell_m1 = CNT_W'(STABLE_CYC - 1);
            PH_WAKE: dwell_m1 = CNT_W'(WAKE_CYC - 1);
            PH_PREA: dwell_m1 = CNT_W'(TRP_CYC - 1);
            default: dwell_m1 = CNT_W'(TMRD_CYC - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_HOLD;
        end else if (last) begin
            phase <= next_phase(phase, merge_dll);
        end
    end

    init_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .dwell_m1 (dwell_m1),
        .first    (first),
        .last     (last)
    );

    init_cmd_drive #(
        .ADDR_W   (ADDR_W),
        .DLL_BIT  (DLL_BIT),
        .PALL_BIT (PALL_BIT)
    ) u_drive (
        .phase   (phase),
        .first   (first),
        .emr_cfg (emr_cfg),
        .mr_cfg  (mr_cfg),
        .cke     (cke),
        .cmd     (cmd),
        .ba      (ba),
        .addr    (addr),
        .ready   (init_done)
    );

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
endmodule

// File: rtl/dram_init_chk.sv
module dram_init_chk #(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DLL_BIT = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [1:0]        ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    logic is_nop, is_pre, is_mrw, is_emr, seen_pre, seen_dll_on;

    assign is_nop = !cs_n && ras_n && cas_n && we_n && (ba == 2'b00) && (addr == '0);
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
    assign is_mrw = !cs_n && !ras_n && !cas_n && !we_n && (ba == 2'b00);
    assign is_emr = !cs_n && !ras_n && !cas_n && !we_n && (ba == 2'b01);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_pre    <= 1'b0;
            seen_dll_on <= 1'b0;
        end else begin
            if (is_pre) seen_pre <= 1'b1;
            if (is_emr && !addr[DLL_BIT]) seen_dll_on <= 1'b1;
        end
    end

    p_quiet_cke_low_r1: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (is_nop && !init_done));

    p_cke_stays_high_r2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    p_pre_before_writes_r3: assert property (@(posedge clk) disable iff (rst)
        (is_emr || is_mrw) |-> seen_pre);

    p_dll_off_first_r4: assert property (@(posedge clk) disable iff (rst)
        (is_emr && addr[DLL_BIT]) |-> !seen_dll_on);

    p_emr_before_mr_r6: assert property (@(posedge clk) disable iff (rst)
        is_mrw |-> seen_dll_on);

    p_single_cycle_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        !is_nop |=> is_nop);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (is_nop && cke));
endmodule

bind dram_init_seq dram_init_chk #(.ADDR_W(ADDR_W), .DLL_BIT(DLL_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/dram_init_seq_bench.sv
module dram_init_seq_bench;
    localparam int AW = 12;
    localparam int S  = 60;
    localparam int W  = 3;
    localparam int RP = 4;
    localparam int MD = 3;
    localparam int RUN_LEN = S + W + RP + 3 * MD + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic merge_dll = 1'b0;
    logic [AW-1:0] emr_cfg = '0;
    logic [AW-1:0] mr_cfg = '0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0] ba;
    logic [AW-1:0] addr;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dram_init_seq #(
        .ADDR_W(AW), .STABLE_CYC(S), .WAKE_CYC(W), .TRP_CYC(RP), .TMRD_CYC(MD)
    ) u_dram_init_seq (
        .clk(clk), .rst(rst), .merge_dll(merge_dll), .emr_cfg(emr_cfg), .mr_cfg(mr_cfg),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    // packed: {cke, done, cs_n, ras_n, cas_n, we_n, ba, addr}
    function automatic logic [AW+7:0] expect_at(int k, logic mg, logic [AW-1:0] e, logic [AW-1:0] m);
        int t_pre = S + W;
        int t_e1  = t_pre + RP;
        int t_mr  = t_e1 + (mg ? MD : 2 * MD);
        logic [AW+7:0] r;
        if (k < S) return {1'b0, 1'b0, 4'b0111, 2'b00, {AW{1'b0}}};
        r = {1'b1, 1'b0, 4'b0111, 2'b00, {AW{1'b0}}};
        if (k == t_pre)                 r = {1'b1, 1'b0, 4'b0010, 2'b00, AW'(12'h100)};
        else if (k == t_e1)             r = {1'b1, 1'b0, 4'b0000, 2'b01, mg ? (e & ~AW'(1)) : (e | AW'(1))};
        else if (!mg && k == t_e1 + MD) r = {1'b1, 1'b0, 4'b0000, 2'b01, e & ~AW'(1)};
        else if (k == t_mr)             r = {1'b1, 1'b0, 4'b0000, 2'b00, m};
        else if (k >= t_mr + MD)        r = {1'b1, 1'b1, 4'b0111, 2'b00, {AW{1'b0}}};
        return r;
    endfunction

    function automatic string tag_at(int k, logic mg);
        int t_pre = S + W;
        int t_e1  = t_pre + RP;
        int t_mr  = t_e1 + (mg ? MD : 2 * MD);
        if (k < S) return "R1";
        if (k < t_pre) return "R2";
        if (k == t_pre) return "R3";
        if (k == t_e1) return mg ? "R5" : "R4";
        if (!mg && k == t_e1 + MD) return "R4";
        if (k == t_mr) return "R6";
        if (k >= t_mr + MD) return "R8";
        return "R7";
    endfunction

    task automatic check(int k, string tag);
        logic [AW+7:0] act, exp_v;
        act   = {cke, init_done, cs_n, ras_n, cas_n, we_n, ba, addr};
        exp_v = expect_at(k, merge_dll, emr_cfg, mr_cfg);
        vectors++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, k, act, exp_v);
        end
    endtask

    task automatic do_reset(int n, string tag);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(0, tag);
        end
        rst = 1'b0;
    endtask

    task automatic run_seq(int len, logic mg, logic [AW-1:0] e, logic [AW-1:0] m);
        merge_dll = mg;
        emr_cfg   = e;
        mr_cfg    = m;
        do_reset(2, "R1");
        check(0, "R1");
        for (int k = 1; k <= len; k++) begin
            @(posedge clk);
            @(negedge clk);
            check(k, tag_at(k, mg));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        run_seq(RUN_LEN, 1'b0, 12'hFFF, 12'h000);
        run_seq(RUN_LEN, 1'b1, 12'hFFF, 12'hFFF);
        run_seq(RUN_LEN, 1'b1, 12'h000, 12'hA5A);
        run_seq(RUN_LEN, 1'b0, 12'h000, 12'h5A5);
        for (int i = 0; i < 12; i++) begin
            int cut = 1 + int'($urandom_range(RUN_LEN - 1));
            run_seq(cut, 1'(($urandom >> 3) & 1), AW'($urandom), AW'($urandom));
            do_reset(1 + int'($urandom_range(2)), "R9");
            run_seq(RUN_LEN, 1'(($urandom >> 5) & 1), AW'($urandom), AW'($urandom));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule